// File: doc/BRIEF.md
# Keyboard/Mouse Controller Host Command Engine

This block is the host-facing command engine of a dual-channel keyboard and mouse controller. The host writes bytes through one write port, with a select input choosing between the data port and the command port. Single-byte commands are decoded at once. They can read or change the configuration byte, run the fixed self-test replies, move the gate-A20 line or request a system reset. Commands that need an argument arm a pending operation, and the next data-port byte completes it.

The block keeps three bytes of state: a configuration (mode) byte whose bits gate the keyboard and mouse interfaces, a status byte, and an output-port byte that drives gate-A20. Replies leave as a one-cycle strobe carrying a byte and a source tag (keyboard side or aux side), and go to a separate output-buffer arbiter. Bytes meant for the keyboard or mouse channel leave on their own one-cycle strobes. All outputs are registered, so every effect of a write shows in the cycle after the clock edge that samples it.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte is 0x18, the output-port byte is 0xCF and a20_gate is 1. All strobes (rsp_valid, kbd_tx_valid, aux_tx_valid, sys_reset_req, bad_cmd) are 0.
- R2: Command 0x20 replies with the current mode byte, tagged keyboard side (rsp_aux=0). Command 0x60 arms a mode write, and the next data byte becomes the mode byte.
- R3: Command 0xD1 arms an output-port write. The next data byte replaces the output-port byte, and a20_gate follows its bit 1. If bit 0 of that byte is 0, sys_reset_req pulses high for exactly one cycle.
- R4: Command 0xD2 makes the next data byte a reply tagged keyboard side (rsp_aux=0). Command 0xD3 makes it a reply tagged aux side (rsp_aux=1).
- R5: Command 0xD4 makes the next data byte go out on the aux channel strobe, and clears mode bit 5.
- R6: A data byte with nothing pending goes out on the keyboard channel strobe and clears mode bit 4. Every data write clears the pending operation.
- R7: Command 0xAD sets mode bit 4 and 0xAE clears it. Command 0xA7 sets mode bit 5 and 0xA8 clears it. No other mode bit changes.
- R8: Command 0xAA sets status bit 2 and replies 0x55. Commands 0xA9 and 0xAB reply 0x00, 0xC0 replies 0x80, and 0xD0 replies with the output-port byte as it stood before the command. All these replies are tagged keyboard side.
- R9: Command 0xDD clears output-port bit 1 and 0xDF sets it. a20_gate follows, and no other output-port bit changes.
- R10: A command in 0xF0..0xFF pulses sys_reset_req for one cycle when its bit 0 is 0, and changes nothing when its bit 0 is 1.
- R11: A command outside the decoded set pulses bad_cmd for one cycle. It produces no reply and leaves mode, status and output port unchanged.
- R12: A command that takes no argument leaves an armed operation pending. A later arming command replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_sel | input | 1 | 0 = data port, 1 = command port |
| wr_byte | input | 8 | Byte written by the host |
| mode_byte | output | 8 | Current configuration byte |
| status_byte | output | 8 | Current status byte |
| outport_byte | output | 8 | Current output-port byte |
| a20_gate | output | 1 | Gate-A20 line (output-port bit 1) |
| rsp_valid | output | 1 | Reply strobe to the output-buffer arbiter |
| rsp_byte | output | 8 | Reply byte |
| rsp_aux | output | 1 | Reply source tag: 0 keyboard side, 1 aux side |
| kbd_tx_valid | output | 1 | Byte forwarded to the keyboard channel |
| kbd_tx_byte | output | 8 | Forwarded keyboard byte |
| aux_tx_valid | output | 1 | Byte forwarded to the mouse channel |
| aux_tx_byte | output | 8 | Forwarded mouse byte |
| sys_reset_req | output | 1 | One-cycle system reset request |
| bad_cmd | output | 1 | One-cycle unrecognised-command strobe |

## Verification
The hardest situation to reach is a pending argument that survives unrelated traffic. An arming command is followed by non-arming, unrecognised or pulse-range commands before its data byte comes, and the outcome depends on the kind of the last arming command. Directed sequences interleave such commands between arming and data. A long random mix of biased command and data writes is then compared against a bench model that tracks the pending kind on its own, so that rearming, double data writes and reset pulses in the middle of a sequence all occur.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Command opcodes
  localparam byte_t OP_RD_MODE  = 8'h20;
  localparam byte_t OP_WR_MODE  = 8'h60;
  localparam byte_t OP_AUX_OFF  = 8'hA7;
  localparam byte_t OP_AUX_ON   = 8'hA8;
  localparam byte_t OP_AUX_TEST = 8'hA9;
  localparam byte_t OP_SELFTEST = 8'hAA;
  localparam byte_t OP_KBD_TEST = 8'hAB;
  localparam byte_t OP_KBD_OFF  = 8'hAD;
  localparam byte_t OP_KBD_ON   = 8'hAE;
  localparam byte_t OP_RD_INP   = 8'hC0;
  localparam byte_t OP_RD_OUTP  = 8'hD0;
  localparam byte_t OP_WR_OUTP  = 8'hD1;
  localparam byte_t OP_KRSP     = 8'hD2;
  localparam byte_t OP_ARSP     = 8'hD3;
  localparam byte_t OP_FWD_AUX  = 8'hD4;
  localparam byte_t OP_A20_OFF  = 8'hDD;
  localparam byte_t OP_A20_ON   = 8'hDF;

  // Fixed reply values
  localparam byte_t RSP_SELFTEST = 8'h55;
  localparam byte_t RSP_TEST_OK  = 8'h00;
  localparam byte_t RSP_INPORT   = 8'h80;

  // Bit positions
  localparam int MB_KDIS     = 4;
  localparam int MB_ADIS     = 5;
  localparam int SB_SELFTEST = 2;
  localparam int OB_RUN      = 0;
  localparam int OB_A20      = 1;

  typedef enum logic [2:0] {
    ARG_NONE, ARG_MODE, ARG_OUTP, ARG_KRSP, ARG_ARSP, ARG_AUX
  } arg_e;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_RSP_MODE, ACT_ARM, ACT_KDIS_SET, ACT_KDIS_CLR,
    ACT_ADIS_SET, ACT_ADIS_CLR, ACT_RSP_CONST, ACT_SELFTEST,
    ACT_RSP_OUTP, ACT_A20_SET, ACT_A20_CLR, ACT_SYS_RST, ACT_BAD
  } act_e;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  byte_t cmd,
  output act_e  act,
  output arg_e  arg,
  output byte_t konst
);
  always_comb begin
    act   = ACT_NONE;
    arg   = ARG_NONE;
    konst = '0;
    if (cmd[7:4] == 4'hF) begin
      act = cmd[0] ? ACT_NONE : ACT_SYS_RST;
    end else begin
      case (cmd)
        OP_RD_MODE:  act = ACT_RSP_MODE;
        OP_WR_MODE:  begin act = ACT_ARM; arg = ARG_MODE; end
        OP_WR_OUTP:  begin act = ACT_ARM; arg = ARG_OUTP; end
        OP_KRSP:     begin act = ACT_ARM; arg = ARG_KRSP; end
        OP_ARSP:     begin act = ACT_ARM; arg = ARG_ARSP; end
        OP_FWD_AUX:  begin act = ACT_ARM; arg = ARG_AUX;  end
        OP_KBD_OFF:  act = ACT_KDIS_SET;
        OP_KBD_ON:   act = ACT_KDIS_CLR;
        OP_AUX_OFF:  act = ACT_ADIS_SET;
        OP_AUX_ON:   act = ACT_ADIS_CLR;
        OP_AUX_TEST: begin act = ACT_RSP_CONST; konst = RSP_TEST_OK; end
        OP_KBD_TEST: begin act = ACT_RSP_CONST; konst = RSP_TEST_OK; end
        OP_RD_INP:   begin act = ACT_RSP_CONST; konst = RSP_INPORT;  end
        OP_SELFTEST: begin act = ACT_SELFTEST;  konst = RSP_SELFTEST; end
        OP_RD_OUTP:  act = ACT_RSP_OUTP;
        OP_A20_OFF:  act = ACT_A20_CLR;
        OP_A20_ON:   act = ACT_A20_SET;
        default:     act = ACT_BAD;
      endcase
    end
  end
endmodule

// File: rtl/kbc_arg_latch.sv
module kbc_arg_latch
  import kbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_fire,
  input  logic data_fire,
  input  logic arm,
  input  arg_e arm_kind,
  output arg_e pend_q
);
  arg_e pend_d;
  logic pend_en;

  always_comb begin
    pend_en = data_fire | (cmd_fire & arm);
    pend_d  = data_fire ? ARG_NONE : arm_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= ARG_NONE;
    else if (pend_en) pend_q <= pend_d;
  end

  // R6
  data_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |=> pend_q == ARG_NONE);

  // R12
  nonarm_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !arm) |=> pend_q == $past(pend_q));
endmodule

// File: rtl/kbc_ctrl_regs.sv
module kbc_ctrl_regs
  import kbc_pkg::*;
#(
  parameter byte_t MODE_INIT    = 8'h03,
  parameter byte_t STATUS_INIT  = 8'h18,
  parameter byte_t OUTPORT_INIT = 8'hCF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_fire,
  input  logic  data_fire,
  input  act_e  act,
  input  byte_t konst,
  input  arg_e  pend,
  input  byte_t wdata,
  output byte_t mode_q,
  output byte_t status_q,
  output byte_t outp_q,
  output logic  rsp_v_q,
  output byte_t rsp_b_q,
  output logic  rsp_aux_q,
  output logic  ktx_v_q,
  output byte_t ktx_b_q,
  output logic  atx_v_q,
  output byte_t atx_b_q,
  output logic  rst_q,
  output logic  bad_q
);
  byte_t mode_d, status_d, outp_d, rsp_b_d, ktx_b_d, atx_b_d;
  logic  rsp_v_d, rsp_aux_d, ktx_v_d, atx_v_d, rst_d, bad_d;
  logic  st_en;

  always_comb begin
    st_en     = cmd_fire | data_fire;
    mode_d    = mode_q;
    status_d  = status_q;
    outp_d    = outp_q;
    rsp_v_d   = 1'b0;
    rsp_b_d   = '0;
    rsp_aux_d = 1'b0;
    ktx_v_d   = 1'b0;
    ktx_b_d   = '0;
    atx_v_d   = 1'b0;
    atx_b_d   = '0;
    rst_d     = 1'b0;
    bad_d     = 1'b0;
    if (cmd_fire) begin
      case (act)
        ACT_RSP_MODE:  begin rsp_v_d = 1'b1; rsp_b_d = mode_q; end
        ACT_RSP_CONST: begin rsp_v_d = 1'b1; rsp_b_d = konst;  end
        ACT_SELFTEST: begin
          status_d[SB_SELFTEST] = 1'b1;
          rsp_v_d = 1'b1;
          rsp_b_d = konst;
        end
        ACT_RSP_OUTP:  begin rsp_v_d = 1'b1; rsp_b_d = outp_q; end
        ACT_KDIS_SET:  mode_d[MB_KDIS] = 1'b1;
        ACT_KDIS_CLR:  mode_d[MB_KDIS] = 1'b0;
        ACT_ADIS_SET:  mode_d[MB_ADIS] = 1'b1;
        ACT_ADIS_CLR:  mode_d[MB_ADIS] = 1'b0;
        ACT_A20_SET:   outp_d[OB_A20] = 1'b1;
        ACT_A20_CLR:   outp_d[OB_A20] = 1'b0;
        ACT_SYS_RST:   rst_d = 1'b1;
        ACT_BAD:       bad_d = 1'b1;
        default: ;
      endcase
    end else if (data_fire) begin
      case (pend)
        ARG_MODE: mode_d = wdata;
        ARG_OUTP: begin
          outp_d = wdata;
          rst_d  = ~wdata[OB_RUN];
        end
        ARG_KRSP: begin rsp_v_d = 1'b1; rsp_b_d = wdata; end
        ARG_ARSP: begin rsp_v_d = 1'b1; rsp_b_d = wdata; rsp_aux_d = 1'b1; end
        ARG_AUX: begin
          atx_v_d = 1'b1;
          atx_b_d = wdata;
          mode_d[MB_ADIS] = 1'b0;
        end
        default: begin
          ktx_v_d = 1'b1;
          ktx_b_d = wdata;
          mode_d[MB_KDIS] = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_INIT;
      status_q <= STATUS_INIT;
      outp_q   <= OUTPORT_INIT;
    end else if (st_en) begin
      mode_q   <= mode_d;
      status_q <= status_d;
      outp_q   <= outp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q   <= 1'b0;
      rsp_b_q   <= '0;
      rsp_aux_q <= 1'b0;
      ktx_v_q   <= 1'b0;
      ktx_b_q   <= '0;
      atx_v_q   <= 1'b0;
      atx_b_q   <= '0;
      rst_q     <= 1'b0;
      bad_q     <= 1'b0;
    end else begin
      rsp_v_q   <= rsp_v_d;
      rsp_b_q   <= rsp_b_d;
      rsp_aux_q <= rsp_aux_d;
      ktx_v_q   <= ktx_v_d;
      ktx_b_q   <= ktx_b_d;
      atx_v_q   <= atx_v_d;
      atx_b_q   <= atx_b_d;
      rst_q     <= rst_d;
      bad_q     <= bad_d;
    end
  end

  // R8
  rsp_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v_q |-> $past(cmd_fire || data_fire));

  // R6
  kbd_fwd_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ktx_v_q |-> !mode_q[MB_KDIS]);

  // R5
  aux_fwd_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    atx_v_q |-> !mode_q[MB_ADIS]);

  // R11
  bad_cmd_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> ($past(cmd_fire) && !rsp_v_q && mode_q == $past(mode_q)
               && outp_q == $past(outp_q) && status_q == $past(status_q)));
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter logic [7:0] MODE_INIT    = 8'h03,
  parameter logic [7:0] STATUS_INIT  = 8'h18,
  parameter logic [7:0] OUTPORT_INIT = 8'hCF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_byte,
  output logic [7:0] mode_byte,
  output logic [7:0] status_byte,
  output logic [7:0] outport_byte,
  output logic       a20_gate,
  output logic       rsp_valid,
  output logic [7:0] rsp_byte,
  output logic       rsp_aux,
  output logic       kbd_tx_valid,
  output logic [7:0] kbd_tx_byte,
  output logic       aux_tx_valid,
  output logic [7:0] aux_tx_byte,
  output logic       sys_reset_req,
  output logic       bad_cmd
);
  logic  cmd_fire, data_fire;
  act_e  dec_act;
  arg_e  dec_arg;
  byte_t dec_konst;
  arg_e  pend;

  assign cmd_fire  = wr_en & wr_sel;
  assign data_fire = wr_en & ~wr_sel;

  kbc_cmd_decode u_dec (
    .cmd   (wr_byte),
    .act   (dec_act),
    .arg   (dec_arg),
    .konst (dec_konst)
  );

  kbc_arg_latch u_arg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_fire),
    .data_fire (data_fire),
    .arm       (dec_act == ACT_ARM),
    .arm_kind  (dec_arg),
    .pend_q    (pend)
  );

  kbc_ctrl_regs #(
    .MODE_INIT    (MODE_INIT),
    .STATUS_INIT  (STATUS_INIT),
    .OUTPORT_INIT (OUTPORT_INIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_fire),
    .data_fire (data_fire),
    .act       (dec_act),
    .konst     (dec_konst),
    .pend      (pend),
    .wdata     (wr_byte),
    .mode_q    (mode_byte),
    .status_q  (status_byte),
    .outp_q    (outport_byte),
    .rsp_v_q   (rsp_valid),
    .rsp_b_q   (rsp_byte),
    .rsp_aux_q (rsp_aux),
    .ktx_v_q   (kbd_tx_valid),
    .ktx_b_q   (kbd_tx_byte),
    .atx_v_q   (aux_tx_valid),
    .atx_b_q   (aux_tx_byte),
    .rst_q     (sys_reset_req),
    .bad_q     (bad_cmd)
  );

  assign a20_gate = outport_byte[OB_A20];

  // R3 R10: a reset request only follows a written byte with bit 0 low
  reset_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> ($past(wr_en) && !$past(wr_byte[0])));

  // R3
  reset_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> (!sys_reset_req || $past(wr_en)));
endmodule

// File: tb/kbc_cmd_engine_test.sv
module kbc_cmd_engine_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] mode_byte, status_byte, outport_byte, rsp_byte, kbd_tx_byte, aux_tx_byte;
  logic       a20_gate, rsp_valid, rsp_aux, kbd_tx_valid, aux_tx_valid, sys_reset_req, bad_cmd;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_mode, m_stat, m_outp;
  int         m_pend;  // 0 none,1 mode,2 outp,3 krsp,4 arsp,5 aux
  logic       e_rv, e_raux, e_kv, e_av, e_rst, e_bad;
  logic [7:0] e_rb, e_kb, e_ab;

  always #(CLK_P/2) clk = ~clk;

  kbc_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .mode_byte(mode_byte), .status_byte(status_byte), .outport_byte(outport_byte),
    .a20_gate(a20_gate), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_aux(rsp_aux),
    .kbd_tx_valid(kbd_tx_valid), .kbd_tx_byte(kbd_tx_byte),
    .aux_tx_valid(aux_tx_valid), .aux_tx_byte(aux_tx_byte),
    .sys_reset_req(sys_reset_req), .bad_cmd(bad_cmd)
  );

  function automatic logic [54:0] obs_now();
    return {mode_byte, status_byte, outport_byte, a20_gate,
            rsp_valid, rsp_valid ? rsp_byte : 8'h00, rsp_valid & rsp_aux,
            kbd_tx_valid, kbd_tx_valid ? kbd_tx_byte : 8'h00,
            aux_tx_valid, aux_tx_valid ? aux_tx_byte : 8'h00,
            sys_reset_req, bad_cmd};
  endfunction

  function automatic logic [54:0] exp_now();
    return {m_mode, m_stat, m_outp, m_outp[1],
            e_rv, e_rv ? e_rb : 8'h00, e_rv & e_raux,
            e_kv, e_kv ? e_kb : 8'h00,
            e_av, e_av ? e_ab : 8'h00,
            e_rst, e_bad};
  endfunction

  task automatic clear_strobes();
    e_rv = 0; e_raux = 0; e_kv = 0; e_av = 0; e_rst = 0; e_bad = 0;
    e_rb = 0; e_kb = 0; e_ab = 0;
  endtask

  task automatic reply(input logic [7:0] b, input logic aux);
    e_rv = 1; e_rb = b; e_raux = aux;
  endtask

  task automatic model(input logic sel, input logic [7:0] b);
    clear_strobes();
    if (sel) begin
      if (b[7:4] == 4'hF) begin
        e_rst = ~b[0];
      end else begin
        case (b)
          8'h20: reply(m_mode, 0);
          8'h60: m_pend = 1;
          8'hD1: m_pend = 2;
          8'hD2: m_pend = 3;
          8'hD3: m_pend = 4;
          8'hD4: m_pend = 5;
          8'hAD: m_mode[4] = 1;
          8'hAE: m_mode[4] = 0;
          8'hA7: m_mode[5] = 1;
          8'hA8: m_mode[5] = 0;
          8'hA9, 8'hAB: reply(8'h00, 0);
          8'hAA: begin m_stat[2] = 1; reply(8'h55, 0); end
          8'hC0: reply(8'h80, 0);
          8'hD0: reply(m_outp, 0);
          8'hDD: m_outp[1] = 0;
          8'hDF: m_outp[1] = 1;
          default: e_bad = 1;
        endcase
      end
    end else begin
      case (m_pend)
        1: m_mode = b;
        2: begin m_outp = b; e_rst = ~b[0]; end
        3: reply(b, 0);
        4: reply(b, 1);
        5: begin e_av = 1; e_ab = b; m_mode[5] = 0; end
        default: begin e_kv = 1; e_kb = b; m_mode[4] = 0; end
      endcase
      m_pend = 0;
    end
  endtask

  task automatic compare(input string tag);
    logic [54:0] a, e;
    a = obs_now();
    e = exp_now();
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic do_write(input logic sel, input logic [7:0] b, input string tag);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_byte = b;
    model(sel, b);
    @(posedge clk); #1;
    compare(tag);
    @(negedge clk);
    wr_en = 0;
    clear_strobes();
    @(posedge clk); #1;
    compare({tag, " idle"});
  endtask

  logic [7:0] cmd_pool [22] = '{8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB,
                                8'hAD, 8'hAE, 8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3,
                                8'hD4, 8'hDD, 8'hDF, 8'hFE, 8'hFF, 8'hF3, 8'h00, 8'h55};

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    m_mode = 8'h03; m_stat = 8'h18; m_outp = 8'hCF; m_pend = 0;
    clear_strobes();
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset");
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    compare("R1 after reset");

    // R2
    do_write(1, 8'h20, "R2 read mode");
    do_write(1, 8'h60, "R2 arm mode");
    do_write(0, 8'hA5, "R2 mode write");
    do_write(1, 8'h20, "R2 read new mode");
    do_write(1, 8'h60, "R2 arm mode");
    do_write(0, 8'h03, "R2 mode restore");
    // R7
    do_write(1, 8'hAD, "R7 kbd off");
    do_write(1, 8'hA7, "R7 aux off");
    do_write(1, 8'hAE, "R7 kbd on");
    do_write(1, 8'hA8, "R7 aux on");
    // R6
    do_write(1, 8'hAD, "R6 kbd off");
    do_write(0, 8'h12, "R6 kbd forward");
    do_write(0, 8'hED, "R6 second forward");
    // R5
    do_write(1, 8'hA7, "R5 aux off");
    do_write(1, 8'hD4, "R5 arm aux");
    do_write(0, 8'h34, "R5 aux forward");
    do_write(0, 8'h35, "R5 follow-up to kbd");
    // R4
    do_write(1, 8'hD2, "R4 arm krsp");
    do_write(0, 8'h77, "R4 kbd reply");
    do_write(1, 8'hD3, "R4 arm arsp");
    do_write(0, 8'h88, "R4 aux reply");
    // R8
    do_write(1, 8'hAA, "R8 self test");
    do_write(1, 8'hA9, "R8 aux test");
    do_write(1, 8'hAB, "R8 kbd test");
    do_write(1, 8'hC0, "R8 input port");
    do_write(1, 8'hD0, "R8 output port");
    // R9
    do_write(1, 8'hDD, "R9 a20 off");
    do_write(1, 8'hD0, "R9 readback");
    do_write(1, 8'hDF, "R9 a20 on");
    // R3
    do_write(1, 8'hD1, "R3 arm outp");
    do_write(0, 8'h02, "R3 outp reset");
    do_write(1, 8'hD1, "R3 arm outp");
    do_write(0, 8'h01, "R3 outp a20 low");
    do_write(1, 8'hD1, "R3 arm outp");
    do_write(0, 8'hCF, "R3 outp restore");
    // R10
    for (int i = 0; i < 16; i++) do_write(1, 8'hF0 | i[7:0], "R10 pulse range");
    // R11
    do_write(1, 8'h00, "R11 bad 00");
    do_write(1, 8'h21, "R11 bad 21");
    do_write(1, 8'hE0, "R11 bad E0");
    do_write(1, 8'hD5, "R11 bad D5");
    // R12
    do_write(1, 8'hD2, "R12 arm krsp");
    do_write(1, 8'hAD, "R12 non-arming");
    do_write(1, 8'h00, "R12 bad between");
    do_write(1, 8'hFF, "R12 no-op between");
    do_write(0, 8'h5A, "R12 pending kept");
    do_write(1, 8'hD2, "R12 arm krsp");
    do_write(1, 8'hD3, "R12 rearm arsp");
    do_write(0, 8'h6B, "R12 rearm wins");

    for (int i = 0; i < 800; i++) begin
      r = $urandom;
      if (r[0])
        do_write(1, r[1] ? cmd_pool[r[15:8] % 22] : r[23:16], "random mix");
      else
        do_write(0, r[23:16], "random mix");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule